// File: doc/BRIEF.md
# Fault-to-Break Routing Lock Register

This block holds one configuration and status register that selects which system fault sources may drive the shared break input of the motor-control timers. Four fault lines are considered: a flash ECC error, a supply-voltage detector interrupt, an SRAM parity error and a CPU lockup. Each has a routing enable. Software can turn an enable on, but only a reset turns it off again, so a routing cannot be removed once it is armed.

The same register holds a parity-error flag. Hardware sets the flag on a parity event. Software clears it by writing 1 to its bit.

The combined break output is the OR of every fault line whose enable is set. It is registered once. The voltage-detector enable also goes out as a lock signal, which makes the detector's enable and level settings read-only elsewhere in the chip.

Top module: `brk_route_lock`

## Requirements
- R1: After reset, `rdata_o` reads 0x000, `brk_o` is 0 and `vd_lock_o` is 0.
- R2: A write (`wr_i` high at a clock edge) with a 1 in bit 3, 2, 1 or 0 sets the enable for the ECC, voltage-detector, parity or lockup source respectively. The enable reads back in the same bit position from the next cycle onward.
- R3: Writing 0 to an enable bit does not clear it. Only an assertion of `rst_ni` clears it.
- R4: `brk_o` equals the OR over the sources of (`fault_i[n]` AND enable n), sampled at the previous clock edge (one register stage). `fault_i` uses the same bit positions as the enables.
- R5: A fault on a source whose enable is clear leaves `brk_o` at 0.
- R6: `vd_lock_o` always equals the voltage-detector enable, bit 2.
- R7: A high `par_evt_i` at a clock edge sets the parity flag, bit 8, from the next cycle onward.
- R8: A write with bit 8 at 1 clears the parity flag. A write with bit 8 at 0 leaves the flag unchanged.
- R9: When a parity event and a write-1-to-clear of bit 8 arrive at the same edge, the flag is 1 afterwards.
- R10: Bits 7:4 and bits 31:9 always read 0, even after a write of all ones to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Current register value |
| fault_i | input | 4 | Fault lines: 3 ECC, 2 voltage detector, 1 parity, 0 lockup |
| par_evt_i | input | 1 | Parity error event, sets flag |
| brk_o | output | 1 | Registered combined break request |
| vd_lock_o | output | 1 | Voltage-detector configuration lock |

## Verification
A lost or spurious enable appears on `rdata_o` one cycle after the write that caused it. Within the next cycle it also appears as a missing or unwanted `brk_o` pulse for a fault on that source. A flag that sets or clears at the wrong time appears at bit 8 in the cycle after the event or the write. The cycle in which event and clear collide tests the set-over-clear priority directly. A break path with the wrong latency shows up as `brk_o` changing one cycle early or late relative to `fault_i`.

// File: rtl/brk_lock_pkg.sv
package brk_lock_pkg;
  parameter int unsigned NUM_SRC  = 4;
  parameter int unsigned FLAG_BIT = 8;

  typedef enum logic [1:0] {
    SRC_LOCKUP = 2'd0,
    SRC_PARITY = 2'd1,
    SRC_VDET   = 2'd2,
    SRC_ECC    = 2'd3
  } src_e;
endpackage

// File: rtl/brk_lock_bits.sv
module brk_lock_bits #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[g] <= 1'b0;
      else if (set_i[g]) q_o[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/brk_parity_flag.sv
module brk_parity_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/brk_combine.sv
module brk_combine #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] fault_i,
  input  logic [N-1:0] en_i,
  output logic         brk_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) brk_o <= 1'b0;
    else         brk_o <= |(fault_i & en_i);
  end
endmodule

// File: rtl/brk_route_lock.sv
module brk_route_lock
  import brk_lock_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [NUM_SRC-1:0] fault_i,
  input  logic               par_evt_i,
  output logic               brk_o,
  output logic               vd_lock_o
);
  logic [NUM_SRC-1:0] lock_q;
  logic               flag_q;
  logic               unused_wdata;

  assign unused_wdata = ^{wdata_i[DATA_W-1:FLAG_BIT+1], wdata_i[FLAG_BIT-1:NUM_SRC]};

  brk_lock_bits #(.N(NUM_SRC)) u_locks (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (wdata_i[NUM_SRC-1:0] & {NUM_SRC{wr_i}}),
    .q_o    (lock_q)
  );

  brk_parity_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (par_evt_i),
    .clr_i  (wr_i & wdata_i[FLAG_BIT]),
    .q_o    (flag_q)
  );

  brk_combine #(.N(NUM_SRC)) u_comb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fault_i (fault_i),
    .en_i    (lock_q),
    .brk_o   (brk_o)
  );

  always_comb begin
    rdata_o                = '0;
    rdata_o[NUM_SRC-1:0]   = lock_q;
    rdata_o[FLAG_BIT]      = flag_q;
  end

  assign vd_lock_o = lock_q[SRC_VDET];
endmodule

// File: rtl/brk_route_lock_chk.sv
module brk_route_lock_chk
  import brk_lock_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic [NUM_SRC-1:0] fault_i,
  input logic               par_evt_i,
  input logic               brk_o,
  input logic               vd_lock_o
);
  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    &(rdata_o[NUM_SRC-1:0] | ~$past(rdata_o[NUM_SRC-1:0]))); // R3

  AST_LOCK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_i) |-> &(rdata_o[NUM_SRC-1:0] | ~$past(wdata_i[NUM_SRC-1:0]))); // R2

  AST_BRK_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o == $past(|(fault_i & rdata_o[NUM_SRC-1:0]))); // R4

  AST_VD_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vd_lock_o == rdata_o[SRC_VDET]); // R6

  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(par_evt_i) |-> rdata_o[FLAG_BIT]); // R7

  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(par_evt_i) && !($past(wr_i) && $past(wdata_i[FLAG_BIT])))
      |-> rdata_o[FLAG_BIT] == $past(rdata_o[FLAG_BIT])); // R8

  AST_FLAG_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(par_evt_i) && $past(wr_i) && $past(wdata_i[FLAG_BIT]))
      |-> !rdata_o[FLAG_BIT]); // R8

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:FLAG_BIT+1] == '0 && rdata_o[FLAG_BIT-1:NUM_SRC] == '0); // R10
endmodule

bind brk_route_lock brk_route_lock_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/brk_route_lock_tb_top.sv
module brk_route_lock_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [3:0]  fault_i = '0;
  logic        par_evt_i = 1'b0;
  logic        brk_o;
  logic        vd_lock_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  brk_route_lock dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // drive at negedge, effect visible at next negedge
  task automatic cyc(input logic wr, input logic [31:0] wd, input logic [3:0] flt, input logic evt);
    wr_i = wr; wdata_i = wd; fault_i = flt; par_evt_i = evt;
    @(negedge clk_i);
    wr_i = 1'b0; wdata_i = '0; par_evt_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    fault_i = '0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    chk("R1 rdata", rdata_o, 32'h0);
    chk("R1 brk", {31'b0, brk_o}, 32'h0);
    chk("R1 vd_lock", {31'b0, vd_lock_o}, 32'h0);
  endtask

  task automatic t_locks();
    cyc(1'b1, 32'h4, 4'h0, 1'b0);
    chk("R2 set vdet", rdata_o, 32'h4);
    chk("R6 vd_lock on", {31'b0, vd_lock_o}, 32'h1);
    cyc(1'b1, 32'h0, 4'h0, 1'b0);
    chk("R3 write 0 keeps", rdata_o, 32'h4);
    cyc(1'b1, 32'h9, 4'h0, 1'b0);
    chk("R2 set ecc+lockup", rdata_o, 32'hD);
    cyc(1'b1, 32'h2, 4'h0, 1'b0);
    chk("R3 older bits kept", rdata_o, 32'hF);
  endtask

  task automatic t_route_partial();
    // only ECC (bit3) and lockup (bit0) armed
    cyc(1'b1, 32'h9, 4'h0, 1'b0);
    cyc(1'b0, 32'h0, 4'h6, 1'b0);
    chk("R5 unarmed faults", {31'b0, brk_o}, 32'h0);
    chk("R6 vd_lock off", {31'b0, vd_lock_o}, 32'h0);
    cyc(1'b0, 32'h0, 4'h8, 1'b0);
    chk("R4 ecc fault", {31'b0, brk_o}, 32'h1);
    cyc(1'b0, 32'h0, 4'h1, 1'b0);
    chk("R4 lockup fault", {31'b0, brk_o}, 32'h1);
    cyc(1'b0, 32'h0, 4'h0, 1'b0);
    chk("R4 fault gone", {31'b0, brk_o}, 32'h0);
    // latency: fault applied, before any edge brk still 0
    fault_i = 4'h8;
    #1;
    chk("R4 not combinational", {31'b0, brk_o}, 32'h0);
    @(negedge clk_i);
    chk("R4 one-cycle latency", {31'b0, brk_o}, 32'h1);
    fault_i = 4'h0;
    @(negedge clk_i);
  endtask

  task automatic t_flag();
    cyc(1'b0, 32'h0, 4'h0, 1'b1);
    chk("R7 flag set", rdata_o, 32'h100);
    cyc(1'b1, 32'h0, 4'h0, 1'b0);
    chk("R8 write 0 keeps flag", rdata_o, 32'h100);
    cyc(1'b1, 32'h100, 4'h0, 1'b0);
    chk("R8 w1c clears", rdata_o, 32'h0);
    cyc(1'b1, 32'h100, 4'h0, 1'b1);
    chk("R9 set beats clear", rdata_o, 32'h100);
    cyc(1'b1, 32'h100, 4'h0, 1'b0);
    chk("R8 clear after collision", rdata_o, 32'h0);
  endtask

  task automatic t_rsvd();
    cyc(1'b1, 32'hFFFF_FEF0, 4'h0, 1'b0);
    chk("R10 reserved read 0", rdata_o, 32'h0);
    cyc(1'b1, 32'hFFFF_FFFF, 4'h0, 1'b1);
    chk("R10 reserved with all ones", rdata_o, 32'h10F);
  endtask

  task automatic t_reset_clears();
    rst_ni = 1'b0;
    #1;
    chk("R3 reset clears locks", rdata_o, 32'h0);
    chk("R1 reset clears vd_lock", {31'b0, vd_lock_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    cyc(1'b0, 32'h0, 4'hF, 1'b0);
    chk("R5 all faults no enables", {31'b0, brk_o}, 32'h0);
    fault_i = 4'h0;
  endtask

  initial begin
    do_reset();
    t_reset();
    t_locks();
    do_reset();
    t_route_partial();
    do_reset();
    t_flag();
    t_rsvd();
    t_reset_clears();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule